// File: doc/BRIEF.md
# Instruction Class Decoder with Condition Gate

This block sorts a fetched 32-bit instruction word into one of twelve instruction classes and decides whether the word may execute under the current condition flags. It builds a 12-bit key from the word, matches it against a fixed set of mask-and-compare patterns in priority order, and reports the class as a one-hot vector. It also reports the few control bits that later stages need, an undefined-instruction flag and an execute-enable.

A valid/ready pair wraps one register stage. A word is taken when both input valid and input ready are high. Its result appears on the outputs after the next clock edge and stays there until the consumer takes it. Each word that is taken gives exactly one result. Words that use the coprocessor space are reported as undefined.

Top module: `insn_class_decoder`

## Requirements
- R1: The key is {word[27:20], word[7:4]}. The out_class output is one-hot, with these bit positions: 0 data processing, 1 multiply, 2 long multiply, 3 swap, 4 halfword/signed transfer, 5 status register transfer, 6 branch-and-exchange, 7 single data transfer, 8 block transfer, 9 branch, 10 software interrupt, 11 undefined.
- R2: When key[11:10]=00, the first matching test sets the class, in this order: key==0x121 gives branch-and-exchange; (key & 0xFCF)==0x009 gives multiply; (key & 0xFBF)==0x109 gives swap; (key & 0xF8F)==0x089 gives long multiply; (key & 0xE49) equal to 0x009 or 0x049 gives halfword transfer; (key & 0xD90)==0x100 gives status transfer. Any other key gives data processing.
- R3: When key[11:10]=01, the class is single data transfer. The one exception is key[9]=1 together with key[0]=1, which gives undefined.
- R4: When key[11:10]=10, key[9]=0 gives block transfer and key[9]=1 gives branch. out_link equals key[8] for a branch and is 0 for every other class.
- R5: When key[11:10]=11, the class is software interrupt when key[9]=1 and key[8]=1. Every other key in this space gives undefined.
- R6: The condition code is word[31:28] and flags are {N,Z,C,V} = in_flags[3:0]. The code passes as follows: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; A N==V; B N!=V; C !Z&(N==V); D Z|(N!=V); E always; F never. For a defined class, out_exec is 1 when the code passes.
- R7: When the condition fails, out_exec is 0. The class and field outputs are still reported.
- R8: When the class is undefined, out_undef is 1 and out_exec is 0, whatever the condition gives. For every other class, out_undef is 0.
- R9: For data processing and single data transfer, out_imm = key[9] and out_sbit = key[4]; for all other classes both are 0. out_dp_op = key[8:5] for data processing and 0 otherwise.
- R10: in_ready is high when out_valid is low or out_ready is high. A word taken at a clock edge is on the outputs, with out_valid high, right after that edge. While out_valid is high and out_ready is low, the outputs hold.
- R11: Each word taken gives one result. When a result is taken and no new word is taken at the same edge, out_valid falls. After reset, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Instruction word |
| in_flags | input | 4 | Condition flags {N,Z,C,V} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 12 | One-hot instruction class |
| out_undef | output | 1 | Undefined instruction |
| out_exec | output | 1 | Condition passed and class defined |
| out_imm | output | 1 | Immediate-operand bit |
| out_sbit | output | 1 | Set-flags or load bit |
| out_link | output | 1 | Branch link bit |
| out_dp_op | output | 4 | Data-processing opcode |

## Verification
The class check uses pairs of words that match more than one pattern in the 00 space, such as a branch-and-exchange key that would also pass the status-transfer mask and a swap key that would also pass the halfword mask. Each pair shows whether the priority order is kept. Words from each of the other three key quadrants sit on both sides of their split bits, which shows that the undefined holes are kept apart from transfers, branches and software interrupts. A fixed data-processing word is sent under all sixteen condition codes with flag sets that make the code pass and then fail, which tells each code's equation apart from its neighbours. Undefined words are then sent with a failing and a never condition, to show that the undefined flag does not depend on the condition. Stalled and drained handshake sequences show that results are held, and that each word taken gives exactly one result.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int WORD_W  = 32;
  localparam int KEY_W   = 12;
  localparam int FLAG_W  = 4;
  localparam int OP_W    = 4;
  localparam int NUM_CLS = 12;

  localparam int C_DP    = 0;
  localparam int C_MUL   = 1;
  localparam int C_MULL  = 2;
  localparam int C_SWP   = 3;
  localparam int C_HALF  = 4;
  localparam int C_PSR   = 5;
  localparam int C_BX    = 6;
  localparam int C_SDT   = 7;
  localparam int C_BLK   = 8;
  localparam int C_BR    = 9;
  localparam int C_SWI   = 10;
  localparam int C_UND   = 11;

  // result word carried through the output stage
  localparam int PAY_W = NUM_CLS + 5 + OP_W;

  function automatic logic [KEY_W-1:0] make_key(input logic [WORD_W-1:0] w);
    return {w[27:20], w[7:4]};
  endfunction

  // flags are {N,Z,C,V}
  function automatic logic cond_holds(input logic [3:0] cc, input logic [FLAG_W-1:0] f);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    // odd codes invert the even partner; 0xF is the inverse of always
    return base ^ cc[0];
  endfunction

endpackage

// File: rtl/key_class_sel.sv
module key_class_sel
  import insn_dec_pkg::*;
(
  input  logic [KEY_W-1:0]   key,
  output logic [NUM_CLS-1:0] cls
);
  logic [1:0] quad;
  assign quad = key[11:10];

  always_comb begin
    cls = '0;
    case (quad)
      2'b00: begin
        if (key == 12'h121)                    cls[C_BX]   = 1'b1;
        else if ((key & 12'hFCF) == 12'h009)   cls[C_MUL]  = 1'b1;
        else if ((key & 12'hFBF) == 12'h109)   cls[C_SWP]  = 1'b1;
        else if ((key & 12'hF8F) == 12'h089)   cls[C_MULL] = 1'b1;
        else if (((key & 12'hE49) == 12'h009) ||
                 ((key & 12'hE49) == 12'h049)) cls[C_HALF] = 1'b1;
        else if ((key & 12'hD90) == 12'h100)   cls[C_PSR]  = 1'b1;
        else                                   cls[C_DP]   = 1'b1;
      end
      2'b01: begin
        if (key[9] && key[0]) cls[C_UND] = 1'b1;
        else                  cls[C_SDT] = 1'b1;
      end
      2'b10: begin
        if (key[9]) cls[C_BR]  = 1'b1;
        else        cls[C_BLK] = 1'b1;
      end
      default: begin
        if (key[9] && key[8]) cls[C_SWI] = 1'b1;
        else                  cls[C_UND] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/field_extract.sv
module field_extract
  import insn_dec_pkg::*;
(
  input  logic [5:0]         key_mid,   // key[9:4]
  input  logic [NUM_CLS-1:0] cls,
  output logic               imm,
  output logic               sbit,
  output logic               link,
  output logic [OP_W-1:0]    dp_op
);
  logic has_ops;
  assign has_ops = cls[C_DP] | cls[C_SDT];
  assign imm     = has_ops & key_mid[5];
  assign sbit    = has_ops & key_mid[0];
  assign link    = cls[C_BR] & key_mid[4];
  assign dp_op   = cls[C_DP] ? key_mid[4:1] : '0;
endmodule

// File: rtl/dec_out_reg.sv
module dec_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = ~vld_q | out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q <= 1'b1;
      dat_q <= in_data;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
  import insn_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_word,
  input  logic [FLAG_W-1:0]  in_flags,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NUM_CLS-1:0] out_class,
  output logic               out_undef,
  output logic               out_exec,
  output logic               out_imm,
  output logic               out_sbit,
  output logic               out_link,
  output logic [OP_W-1:0]    out_dp_op
);
  logic [KEY_W-1:0]   key_w;
  logic [NUM_CLS-1:0] cls_w;
  logic               cond_ok_w;
  logic               undef_w;
  logic               exec_w;
  logic               imm_w, sbit_w, link_w;
  logic [OP_W-1:0]    op_w;
  logic [PAY_W-1:0]   pay_d, pay_q;
  logic               unused_bits;

  assign key_w       = make_key(in_word);
  assign unused_bits = ^{key_w[11:10], key_w[3:0]};

  key_class_sel u_cls (
    .key (key_w),
    .cls (cls_w)
  );

  assign cond_ok_w = cond_holds(in_word[31:28], in_flags);
  assign undef_w   = cls_w[C_UND];
  assign exec_w    = cond_ok_w & ~undef_w;

  field_extract u_fld (
    .key_mid (key_w[9:4]),
    .cls     (cls_w),
    .imm     (imm_w),
    .sbit    (sbit_w),
    .link    (link_w),
    .dp_op   (op_w)
  );

  assign pay_d = {cls_w, undef_w, exec_w, imm_w, sbit_w, link_w, op_w};

  dec_out_reg #(.W(PAY_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_q)
  );

  assign {out_class, out_undef, out_exec, out_imm, out_sbit, out_link, out_dp_op} = pay_q;
endmodule

// File: rtl/insn_class_decoder_chk.sv
module insn_class_decoder_chk
  import insn_dec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NUM_CLS-1:0] out_class,
  input logic               out_undef,
  input logic               out_exec,
  input logic               out_imm,
  input logic               out_sbit,
  input logic               out_link,
  input logic [OP_W-1:0]    out_dp_op
);
  p_onehot_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_class) == 1));

  p_undef_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_undef == out_class[C_UND]));

  p_undef_noexec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_undef && out_exec));

  p_link_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_link) |-> out_class[C_BR]);

  p_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_class[C_DP] && !out_class[C_SDT]) |-> (!out_imm && !out_sbit));

  p_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_class[C_DP]) |-> (out_dp_op == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class) &&
                                   $stable(out_exec) && $stable(out_dp_op)));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

bind insn_class_decoder insn_class_decoder_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_class (out_class),
  .out_undef (out_undef),
  .out_exec  (out_exec),
  .out_imm   (out_imm),
  .out_sbit  (out_sbit),
  .out_link  (out_link),
  .out_dp_op (out_dp_op)
);

// File: tb/insn_class_decoder_tb_top.sv
module insn_class_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic [3:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_class;
  logic        out_undef, out_exec, out_imm, out_sbit, out_link;
  logic [3:0]  out_dp_op;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  insn_class_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .in_flags  (in_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_class (out_class),
    .out_undef (out_undef),
    .out_exec  (out_exec),
    .out_imm   (out_imm),
    .out_sbit  (out_sbit),
    .out_link  (out_link),
    .out_dp_op (out_dp_op)
  );

  // {req, word, flags{N,Z,C,V}, class, undef, exec, imm, sbit, link, op}
  localparam int NV = 38;
  localparam logic [64:0] VEC [NV] = '{
    {8'd2, 32'hE12FFF10, 4'b0000, 12'h040, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 bx over status mask
    {8'd2, 32'hE0000090, 4'b0000, 12'h002, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 mul over halfword
    {8'd2, 32'hE0300090, 4'b0000, 12'h002, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 mul accumulate
    {8'd2, 32'hE1000090, 4'b0000, 12'h008, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 swap over halfword
    {8'd2, 32'hE0800090, 4'b0000, 12'h004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 long mul
    {8'd2, 32'hE1D000B0, 4'b0000, 12'h010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 halfword
    {8'd2, 32'hE10F0000, 4'b0000, 12'h020, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R2 status
    {8'd9, 32'hE2910001, 4'b0000, 12'h001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h4}, // R9 dp imm S
    {8'd9, 32'hE1A00001, 4'b0000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R9 dp reg
    {8'd3, 32'hE5910000, 4'b0000, 12'h080, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0}, // R3 load imm
    {8'd3, 32'hE7810002, 4'b0000, 12'h080, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0}, // R3 store reg
    {8'd3, 32'hE7000010, 4'b0000, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0}, // R3 hole
    {8'd4, 32'hE8BD0001, 4'b0000, 12'h100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R4 block
    {8'd4, 32'hEA000000, 4'b0000, 12'h200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R4 branch
    {8'd4, 32'hEB000000, 4'b0000, 12'h200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0}, // R4 branch link
    {8'd5, 32'hEF000000, 4'b0000, 12'h400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0}, // R5 swi
    {8'd5, 32'hEE000000, 4'b0000, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0}, // R5 cop op
    {8'd5, 32'hEC000000, 4'b0000, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0}, // R5 cop xfer
    {8'd6, 32'h01A00001, 4'b0100, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 EQ
    {8'd7, 32'h01A00001, 4'b0000, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 EQ fail
    {8'd6, 32'h11A00001, 4'b0000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 NE
    {8'd6, 32'h21A00001, 4'b0010, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 CS
    {8'd7, 32'h31A00001, 4'b0010, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 CC fail
    {8'd6, 32'h41A00001, 4'b1000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 MI
    {8'd7, 32'h51A00001, 4'b1000, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 PL fail
    {8'd6, 32'h61A00001, 4'b0001, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 VS
    {8'd6, 32'h71A00001, 4'b0000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 VC
    {8'd6, 32'h81A00001, 4'b0010, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 HI
    {8'd7, 32'h81A00001, 4'b0110, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 HI fail
    {8'd6, 32'h91A00001, 4'b0110, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 LS
    {8'd6, 32'hA1A00001, 4'b1001, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 GE
    {8'd7, 32'hB1A00001, 4'b1001, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 LT fail
    {8'd6, 32'hC1A00001, 4'b0000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 GT
    {8'd7, 32'hC1A00001, 4'b0100, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 GT fail
    {8'd6, 32'hD1A00001, 4'b1000, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hD}, // R6 LE
    {8'd7, 32'hF1A00001, 4'b1111, 12'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hD}, // R7 never
    {8'd8, 32'h07000010, 4'b0000, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0}, // R8 undef cond fail
    {8'd8, 32'hF7000010, 4'b1111, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0}  // R8 undef never
  };

  function automatic logic [20:0] result_now();
    return {out_class, out_undef, out_exec, out_imm, out_sbit, out_link, out_dp_op};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [20:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 reset valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10 reset ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: back-to-back words, consumer always ready
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_word  = VEC[i][56:25];
      in_flags = VEC[i][24:21];
      @(negedge clk);
      check(out_valid == 1'b1, $sformatf("R10 valid vec%0d", i), 64'(out_valid), 64'd1);
      check(result_now() == VEC[i][20:0], $sformatf("R%0d vec%0d", VEC[i][64:57], i),
            64'(result_now()), 64'(VEC[i][20:0]));
      check($countones(out_class) == 1, $sformatf("R1 onehot vec%0d", i), 64'(out_class), 64'd1);
    end

    // R11 drain: no new word, result taken, valid falls
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 drain", 64'(out_valid), 64'd0);

    // R10 stall: present branch-link, consumer not ready
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = 32'hEB000000;
    in_flags  = 4'b0000;
    @(negedge clk);
    held = result_now();
    check(out_valid && held == {12'h200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0}, "R10 stall load",
          64'(held), 64'({12'h200, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0}));
    check(in_ready == 1'b0, "R10 ready low on stall", 64'(in_ready), 64'd0);
    in_word = 32'hEF000000;   // swi waits behind the stalled result
    repeat (2) @(negedge clk);
    check(result_now() == held, "R10 hold during stall", 64'(result_now()), 64'(held));
    check(out_valid == 1'b1, "R10 valid during stall", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_class == 12'h400, "R11 next word after stall", 64'(out_class), 64'h400);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 single result per word", 64'(out_valid), 64'd0);

    // R8 undefined in a passing condition still blocks exec
    in_valid = 1'b1;
    in_word  = 32'hEE000000;
    @(negedge clk);
    check(out_undef == 1'b1 && out_exec == 1'b0, "R8 undef always-cond",
          64'({out_undef, out_exec}), 64'b10);
    in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule